// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block is one eight-pin general-purpose port driven by a byte-wide register interface that lives inside a 256-byte I/O window. A host writes four configuration registers and reads them back, plus a read-only register that reflects the live pad levels. Per pin, the port either behaves as a plain host-controlled I/O bit or repeats one bit of the bus address that was captured from the multiplexed address/data lines with the address-latch-enable strobe.

Independently of that mode choice, every pin chooses a push-pull or an open-drain output driver. In open-drain mode a logical one releases the pad (output enable removed) and a logical zero pulls it low. The block presents output-value and output-enable signals per pin to the pad ring and takes the sampled pad level back on its input.

Top module: `gpio_port_bank`

## Requirements
- R1: While the active-low reset is low, all configuration registers and the captured address clear to 00h, so every pin's output enable is 0.
- R2: A register write takes effect at the rising clock edge where the window select and the write strobe are both high; a write with the window select low changes nothing.
- R3: Register offsets: 00h pin levels (read-only), 02h mode (0 = I/O bit, 1 = captured-address bit), 04h output value, 06h direction (0 = input, 1 = output), 08h driver (0 = push-pull, 1 = open-drain). Each writable register reads back its stored value.
- R4: Reads of any offset other than the five above, and any read with the window select low, return 00h.
- R5: A pin in I/O mode with push-pull driver presents its output-value bit and asserts output enable exactly when its direction bit is 1.
- R6: A pin in captured-address mode presents the matching captured address bit and is enabled regardless of its direction bit (push-pull driver).
- R7: A pin with the open-drain driver presents value 0; its output enable is asserted only when the pin is enabled and the bit it would drive is 0.
- R8: The captured address loads the multiplexed bus value at each rising edge where the address-latch-enable is high and holds otherwise.
- R9: Writing offset 00h changes no register; reading 00h always returns the current pin inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 1 | Select for the 256-byte I/O window |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | 8 | Byte offset inside the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| mux_ad | input | 8 | Multiplexed address/data lines |
| ale | input | 1 | Address-latch-enable strobe |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Value presented to each pad |
| pin_oe | output | 8 | Output enable for each pad |

## Verification
The assertions assume the host bus and the address strobe are synchronous to the clock: the window select, write strobe, offset, write data, multiplexed lines and strobe are stable around each rising edge. The bench drives every one of them on the falling edge and holds it for a full cycle, so each write and each capture lands at exactly one known edge. Pad inputs are treated as free-running, and the bench changes them only between reads.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_PIN_LVL = 8'h00;
    localparam logic [OFF_W-1:0] OFF_MODE    = 8'h02;
    localparam logic [OFF_W-1:0] OFF_OVAL    = 8'h04;
    localparam logic [OFF_W-1:0] OFF_DIR     = 8'h06;
    localparam logic [OFF_W-1:0] OFF_DRIVE   = 8'h08;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_sel,
    input  logic             bus_wr,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     mode_q,
    output logic [W-1:0]     oval_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     drive_q
);
    typedef struct packed {
        logic [W-1:0] mode;
        logic [W-1:0] oval;
        logic [W-1:0] dir;
        logic [W-1:0] drive;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_en;

    always_comb begin
        cfg_d = cfg_q;
        wr_en = win_sel && bus_wr;
        if (wr_en) begin
            case (bus_off)
                OFF_MODE:  cfg_d.mode  = bus_wdata;
                OFF_OVAL:  cfg_d.oval  = bus_wdata;
                OFF_DIR:   cfg_d.dir   = bus_wdata;
                OFF_DRIVE: cfg_d.drive = bus_wdata;
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_q  = cfg_q.mode;
    assign oval_q  = cfg_q.oval;
    assign dir_q   = cfg_q.dir;
    assign drive_q = cfg_q.drive;
endmodule

// File: rtl/gpio_addr_latch.sv
module gpio_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] mux_ad,
    output logic [W-1:0] addr_q
);
    logic [W-1:0] addr_d;
    logic [W-1:0] addr_r;

    always_comb begin
        addr_d = addr_r;
        if (ale) addr_d = mux_ad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_r <= '0;
        else        addr_r <= addr_d;
    end

    assign addr_q = addr_r;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
    input  logic mode,
    input  logic oval,
    input  logic dir,
    input  logic drive,
    input  logic addr_bit,
    output logic pad_out,
    output logic pad_oe
);
    logic want_val;
    logic want_en;

    always_comb begin
        want_val = mode ? addr_bit : oval;
        want_en  = mode | dir;
        if (drive) begin
            pad_out = 1'b0;
            pad_oe  = want_en & ~want_val;
        end else begin
            pad_out = want_val;
            pad_oe  = want_en;
        end
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_sel,
    input  logic             bus_wr,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     mux_ad,
    input  logic             ale,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    logic [W-1:0] mode_q;
    logic [W-1:0] oval_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] drive_q;
    logic [W-1:0] addr_q;

    gpio_port_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_sel   (win_sel),
        .bus_wr    (bus_wr),
        .bus_off   (bus_off),
        .bus_wdata (bus_wdata),
        .mode_q    (mode_q),
        .oval_q    (oval_q),
        .dir_q     (dir_q),
        .drive_q   (drive_q)
    );

    gpio_addr_latch #(.W(W)) u_alat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale    (ale),
        .mux_ad (mux_ad),
        .addr_q (addr_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_cell u_cell (
            .mode     (mode_q[i]),
            .oval     (oval_q[i]),
            .dir      (dir_q[i]),
            .drive    (drive_q[i]),
            .addr_bit (addr_q[i]),
            .pad_out  (pin_out[i]),
            .pad_oe   (pin_oe[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (win_sel) begin
            case (bus_off)
                OFF_PIN_LVL: bus_rdata = pin_in;
                OFF_MODE:    bus_rdata = mode_q;
                OFF_OVAL:    bus_rdata = oval_q;
                OFF_DIR:     bus_rdata = dir_q;
                OFF_DRIVE:   bus_rdata = drive_q;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_bank_checker.sv
module gpio_port_bank_checker
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_sel,
    input logic             bus_wr,
    input logic [OFF_W-1:0] bus_off,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     mux_ad,
    input logic             ale,
    input logic [W-1:0]     pin_out,
    input logic [W-1:0]     pin_oe,
    input logic [W-1:0]     mode_q,
    input logic [W-1:0]     dir_q,
    input logic [W-1:0]     drive_q,
    input logic [W-1:0]     addr_q
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && addr_q == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && bus_wr && bus_off == OFF_DIR) |=> dir_q == $past(bus_wdata));

    assert_no_select_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_sel |=> ($stable(dir_q) && $stable(mode_q) && $stable(drive_q)));

    assert_addr_mode_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q & ~drive_q & ~pin_oe) == '0));

    assert_open_drain_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((drive_q & pin_out) == '0));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> addr_q == $past(mux_ad));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_q));
endmodule

bind gpio_port_bank gpio_port_bank_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_sel   (win_sel),
    .bus_wr    (bus_wr),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .mux_ad    (mux_ad),
    .ale       (ale),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mode_q    (mode_q),
    .dir_q     (dir_q),
    .drive_q   (drive_q),
    .addr_q    (addr_q)
);

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_off = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] mux_ad = 8'h00;
    logic       ale = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_bank #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_ad(mux_ad), .ale(ale), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [7:0] data, input logic sel);
        @(negedge clk);
        win_sel = sel; bus_wr = 1'b1; bus_off = off; bus_wdata = data;
        @(negedge clk);
        win_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic sel, output logic [7:0] data);
        @(negedge clk);
        win_sel = sel; bus_wr = 1'b0; bus_off = off;
        #1 data = bus_rdata;
        win_sel = 1'b0;
    endtask

    task automatic capture(input logic [7:0] a);
        @(negedge clk);
        mux_ad = a; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; mux_ad = ~a;
    endtask

    // Expected pad behaviour computed from R5, R6 and R7
    function automatic logic [15:0] model(input logic [7:0] md, input logic [7:0] ov,
                                          input logic [7:0] dr, input logic [7:0] dv,
                                          input logic [7:0] ad);
        logic [7:0] o, e;
        for (int i = 0; i < 8; i++) begin
            logic v, en;
            v  = md[i] ? ad[i] : ov[i];
            en = md[i] | dr[i];
            o[i] = dv[i] ? 1'b0 : v;
            e[i] = dv[i] ? (en & ~v) : en;
        end
        return {e, o};
    endfunction

    initial begin
        logic [7:0] r;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", pin_oe, 8'h00);
        rst_n = 1'b1;
        rd(8'h02, 1'b1, r); check("R1 mode", r, 8'h00);
        rd(8'h04, 1'b1, r); check("R1 oval", r, 8'h00);
        rd(8'h06, 1'b1, r); check("R1 dir", r, 8'h00);
        rd(8'h08, 1'b1, r); check("R1 drive", r, 8'h00);

        // R4: unused offsets and deselected reads
        for (int off = 0; off < 256; off++) begin
            logic [7:0] o8;
            o8 = off[7:0];
            if (o8 != 8'h00 && o8 != 8'h02 && o8 != 8'h04 && o8 != 8'h06 && o8 != 8'h08) begin
                rd(o8, 1'b1, r); check("R4 unused", r, 8'h00);
            end
        end
        wr(8'h06, 8'hA5, 1'b1);
        rd(8'h06, 1'b0, r); check("R4 deselected", r, 8'h00);

        // R2: write without window select ignored
        wr(8'h06, 8'h3C, 1'b0);
        rd(8'h06, 1'b1, r); check("R2 no select", r, 8'hA5);

        // R9: pin level register read-only, tracks pin_in
        wr(8'h00, 8'hFF, 1'b1);
        rd(8'h06, 1'b1, r); check("R9 dir kept", r, 8'hA5);
        rd(8'h02, 1'b1, r); check("R9 mode kept", r, 8'h00);
        for (int p = 0; p < 256; p += 17) begin
            pin_in = p[7:0];
            rd(8'h00, 1'b1, r); check("R9 pin level", r, p[7:0]);
        end

        // R8: hold without strobe
        wr(8'h02, 8'hFF, 1'b1);
        wr(8'h06, 8'h00, 1'b1);
        capture(8'h5A);
        check("R8 capture", pin_out, 8'h5A);
        @(negedge clk); mux_ad = 8'hC3;
        @(negedge clk); #1;
        check("R8 hold", pin_out, 8'h5A);
        check("R6 enabled", pin_oe, 8'hFF);

        // Sweep R3, R5, R6, R7
        for (int k = 0; k < 256; k++) begin
            logic [7:0] md, ov, dr, dv, ad;
            md = 8'(k * 29); ov = 8'(k * 37 + 1); dr = 8'(k * 53 + 7);
            dv = 8'(k * 91 + 3); ad = 8'(k * 113 + 5);
            wr(8'h02, md, 1'b1); wr(8'h04, ov, 1'b1);
            wr(8'h06, dr, 1'b1); wr(8'h08, dv, 1'b1);
            capture(ad);
            #1;
            exp = model(md, ov, dr, dv, ad);
            check("R5/R6/R7 pin_out", pin_out, exp[7:0]);
            check("R5/R6/R7 pin_oe", pin_oe, exp[15:8]);
            rd(8'h02, 1'b1, r); check("R3 mode", r, md);
            rd(8'h04, 1'b1, r); check("R3 oval", r, ov);
            rd(8'h06, 1'b1, r); check("R3 dir", r, dr);
            rd(8'h08, 1'b1, r); check("R3 drive", r, dv);
        end

        // R1: reset in the middle of operation
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 mid oe", pin_oe, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h08, 1'b1, r); check("R1 mid drive", r, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule